// File: doc/BRIEF.md
# Inter-Core Mailbox Send Controller

This block is the transmit side of a mailbox between processor cores. A local bus master places a 64-bit message in two 32-bit holding registers, writes the number of the core that should receive it, and then writes a launch register. On launch the message is copied into a small queue owned by that destination. Each destination core drains its own queue through a valid/pop handshake, which stands for the remote core fetching the message.

For every destination the block reports three conditions in a single status word: a message is still waiting (pending), a message has been fetched (delivered), and a message was lost because the queue was full (dropped). Delivered and dropped flags persist until software clears them through a dedicated flag-clear register. Either flag can raise a pending interrupt, subject to per-source masks and a global mask. Software clears the pending interrupt by writing 1 to bit 0 of its register.

Top module: `mbox_send_ctrl`

## Requirements
- R1: After reset the status word and the interrupt register read 0, the mask register reads 3'b111, `irq` is low and no destination shows valid.
- R2: The low word (0x04) and high word (0x08) registers read back the last value written; the target register (0x00) keeps only its low 3 bits.
- R3: A write to 0x0C with bit 0 set appends {high word, low word} to the queue of the destination in the target register; a write to 0x0C with bit 0 clear has no effect.
- R4: Each destination queue is first-in first-out; `dstValid[d]` and status bit d (bits [7:0], pending) are 1 exactly while queue d holds a message, and `dstData` slice d shows its oldest entry.
- R5: A launch toward a queue already holding 4 messages discards the message, leaves the queue unchanged and sets status bit 8+d (dropped).
- R6: A pop while `dstValid[d]` is 1 removes the oldest entry and sets status bit 16+d (delivered); a pop on an empty queue changes nothing.
- R7: Writing to the flag-clear register (0x10) clears each delivered and dropped flag whose status bit position is set in the written data; pending bits are not affected.
- R8: Bit 0 of the interrupt register (0x18) becomes 1 one cycle after any delivered flag is set with mask bit 2 clear, or any dropped flag is set with mask bit 1 clear; writing 1 to bit 0 clears it once no such flag remains.
- R9: `irq` equals interrupt register bit 0 while mask bit 0 is clear and is 0 while mask bit 0 is set.
- R10: A flag whose source is masked (bit 2 for delivered, bit 1 for dropped) does not set the interrupt register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Bus access strobe |
| reqWrite | input | 1 | 1 for write, with reqValid |
| reqAddr | input | 8 | Byte address of the register |
| reqWdata | input | 32 | Write data |
| rspRdata | output | 32 | Read data for reqAddr (combinational) |
| dstValid | output | 8 | Per-destination queue not empty |
| dstData | output | 512 | Oldest message of each destination, 64 bits per destination, destination d at [64d+63:64d] |
| dstPop | input | 8 | Per-destination fetch strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: eight destinations and a queue depth of four. Depth four keeps the full-queue drop reachable with five launches, so the dropped flag, the untouched queue contents and the drop-driven interrupt are all checked on the same destination. Eight destinations place the three flag fields side by side in the status word, which lets the flag-clear tests show that pending bits survive a clear.

// File: rtl/mbox_send_pkg.sv
package mbox_send_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned MSG_W = 64;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned FIELD_W = 8;

  localparam logic [ADDR_W-1:0] OFF_TARGET = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LOW    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_HIGH   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_LAUNCH = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IRQ    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h1C;

  typedef struct packed {
    logic             wrLow;
    logic             wrHigh;
    logic             wrTarget;
    logic             launch;
    logic             clrFlags;
    logic             clrIrq;
    logic             wrMask;
    logic [REG_W-1:0] wdata;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    SEL_TARGET,
    SEL_LOW,
    SEL_HIGH,
    SEL_STATUS,
    SEL_IRQ,
    SEL_MASK,
    SEL_ZERO
  } rdSel_t;

endpackage

// File: rtl/mbox_dst_fifo.sv
module mbox_dst_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             valid,
  output logic             full,
  output logic [WIDTH-1:0] headData
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign valid    = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && valid;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R5

  AST_FULL_PUSH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (full && $stable(headData))); // R5

  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && pop && !push) |=> !valid); // R6

endmodule

// File: rtl/mbox_send_ctl.sv
module mbox_send_ctl
  import mbox_send_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [REG_W-1:0]  reqWdata,
  output ctlStrobes_t       stb,
  output rdSel_t            rdSel
);

  logic wrEn;
  assign wrEn = reqValid && reqWrite;

  always_comb begin
    stb          = '0;
    stb.wdata    = reqWdata;
    stb.wrTarget = wrEn && (reqAddr == OFF_TARGET);
    stb.wrLow    = wrEn && (reqAddr == OFF_LOW);
    stb.wrHigh   = wrEn && (reqAddr == OFF_HIGH);
    stb.launch   = wrEn && (reqAddr == OFF_LAUNCH) && reqWdata[0];
    stb.clrFlags = wrEn && (reqAddr == OFF_CLEAR);
    stb.clrIrq   = wrEn && (reqAddr == OFF_IRQ);
    stb.wrMask   = wrEn && (reqAddr == OFF_MASK);
  end

  always_comb begin
    case (reqAddr)
      OFF_TARGET: rdSel = SEL_TARGET;
      OFF_LOW:    rdSel = SEL_LOW;
      OFF_HIGH:   rdSel = SEL_HIGH;
      OFF_STATUS: rdSel = SEL_STATUS;
      OFF_IRQ:    rdSel = SEL_IRQ;
      OFF_MASK:   rdSel = SEL_MASK;
      default:    rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/mbox_send_dp.sv
module mbox_send_dp
  import mbox_send_pkg::*;
#(
  parameter int unsigned NUM_DST = 8,
  parameter int unsigned DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              stb,
  input  rdSel_t                   rdSel,
  input  logic [NUM_DST-1:0]       dstPop,
  output logic [REG_W-1:0]         rdData,
  output logic [NUM_DST-1:0]       dstValid,
  output logic [NUM_DST*MSG_W-1:0] dstData,
  output logic                     irq
);

  localparam int unsigned ID_W = (NUM_DST > 1) ? $clog2(NUM_DST) : 1;

  logic [REG_W-1:0]   msgLow, msgHigh;
  logic [ID_W-1:0]    targetId;
  logic [2:0]         maskReg;
  logic [NUM_DST-1:0] deliv, drop, fifoFull, delivEv, dropEv, pushVec;
  logic [NUM_DST-1:0] clrDeliv, clrDrop;
  logic               irqPend, srcActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgLow   <= '0;
      msgHigh  <= '0;
      targetId <= '0;
      maskReg  <= 3'b111;
    end else begin
      if (stb.wrLow)    msgLow   <= stb.wdata;
      if (stb.wrHigh)   msgHigh  <= stb.wdata;
      if (stb.wrTarget) targetId <= stb.wdata[ID_W-1:0];
      if (stb.wrMask)   maskReg  <= stb.wdata[2:0];
    end
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    assign pushVec[d] = stb.launch && (targetId == ID_W'(d));
    assign dropEv[d]  = pushVec[d] && fifoFull[d];
    assign delivEv[d] = dstPop[d] && dstValid[d];

    mbox_dst_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (MSG_W)
    ) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushVec[d]),
      .pushData ({msgHigh, msgLow}),
      .pop      (dstPop[d]),
      .valid    (dstValid[d]),
      .full     (fifoFull[d]),
      .headData (dstData[d*MSG_W +: MSG_W])
    );
  end

  assign clrDeliv = stb.clrFlags ? stb.wdata[2*FIELD_W +: NUM_DST] : '0;
  assign clrDrop  = stb.clrFlags ? stb.wdata[FIELD_W +: NUM_DST]   : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deliv <= '0;
      drop  <= '0;
    end else begin
      deliv <= (deliv & ~clrDeliv) | delivEv;
      drop  <= (drop & ~clrDrop) | dropEv;
    end
  end

  assign srcActive = ((|deliv) && !maskReg[2]) || ((|drop) && !maskReg[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPend <= 1'b0;
    else       irqPend <= srcActive || (irqPend && !(stb.clrIrq && stb.wdata[0]));
  end

  assign irq = irqPend && !maskReg[0];

  logic [FIELD_W-1:0] busyField, dropField, delivField;
  always_comb begin
    busyField  = '0;
    dropField  = '0;
    delivField = '0;
    busyField[NUM_DST-1:0]  = dstValid;
    dropField[NUM_DST-1:0]  = drop;
    delivField[NUM_DST-1:0] = deliv;
  end

  always_comb begin
    case (rdSel)
      SEL_TARGET: rdData = REG_W'(targetId);
      SEL_LOW:    rdData = msgLow;
      SEL_HIGH:   rdData = msgHigh;
      SEL_STATUS: rdData = {{(REG_W-3*FIELD_W){1'b0}}, delivField, dropField, busyField};
      SEL_IRQ:    rdData = {{(REG_W-1){1'b0}}, irqPend};
      SEL_MASK:   rdData = {{(REG_W-3){1'b0}}, maskReg};
      default:    rdData = '0;
    endcase
  end

  AST_DROP_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (dropEv != '0) |=> ((drop & $past(dropEv)) == $past(dropEv))); // R5

  AST_DELIV_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (delivEv != '0) |=> ((deliv & $past(delivEv)) == $past(delivEv))); // R6

  AST_CLEAR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlags && !stb.launch && dstPop == '0) |=> $stable(dstValid)); // R7

  AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPend && !srcActive) |=> !irqPend); // R10

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqPend); // R9

endmodule

// File: rtl/mbox_send_ctrl.sv
module mbox_send_ctrl
  import mbox_send_pkg::*;
#(
  parameter int unsigned NUM_DST = 8,
  parameter int unsigned DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [REG_W-1:0]         reqWdata,
  output logic [REG_W-1:0]         rspRdata,
  output logic [NUM_DST-1:0]       dstValid,
  output logic [NUM_DST*MSG_W-1:0] dstData,
  input  logic [NUM_DST-1:0]       dstPop,
  output logic                     irq
);

  ctlStrobes_t stb;
  rdSel_t      rdSel;

  mbox_send_ctl u_ctl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .stb      (stb),
    .rdSel    (rdSel)
  );

  mbox_send_dp #(
    .NUM_DST (NUM_DST),
    .DEPTH   (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .dstPop   (dstPop),
    .rdData   (rspRdata),
    .dstValid (dstValid),
    .dstData  (dstData),
    .irq      (irq)
  );

  initial begin
    AST_DST_FITS_FIELD: assert (NUM_DST >= 1 && NUM_DST <= FIELD_W); // R4
  end

endmodule

// File: tb/mbox_send_ctrl_test.sv
module mbox_send_ctrl_test;

  localparam int NUM_DST = 8;
  localparam int DEPTH   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rspRdata;
  logic [NUM_DST-1:0] dstValid;
  logic [NUM_DST*64-1:0] dstData;
  logic [NUM_DST-1:0] dstPop = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_send_ctrl #(.NUM_DST(NUM_DST), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .dstValid(dstValid), .dstData(dstData), .dstPop(dstPop), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    reqAddr = a;
    #1;
    d = rspRdata;
  endtask

  task automatic sendMsg(input int dst, input logic [63:0] m);
    busWrite(8'h04, m[31:0]);
    busWrite(8'h08, m[63:32]);
    busWrite(8'h00, 32'(dst));
    busWrite(8'h0C, 32'h1);
  endtask

  task automatic popDst(input int dst);
    @(negedge clk);
    dstPop[dst] = 1'b1;
    @(negedge clk);
    dstPop = '0;
  endtask

  function automatic logic [63:0] headOf(input int dst);
    return dstData[dst*64 +: 64];
  endfunction

  task automatic testReset();
    logic [31:0] v;
    busRead(8'h14, v); check("R1", "status after reset", 64'(v), 64'h0);
    busRead(8'h18, v); check("R1", "irq reg after reset", 64'(v), 64'h0);
    busRead(8'h1C, v); check("R1", "mask after reset", 64'(v), 64'h7);
    check("R1", "irq pin after reset", 64'(irq), 64'h0);
    check("R1", "dstValid after reset", 64'(dstValid), 64'h0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    busWrite(8'h04, 32'hCAFE_0001);
    busWrite(8'h08, 32'hBEEF_0002);
    busWrite(8'h00, 32'hFFFF_FFFD);
    busRead(8'h04, v); check("R2", "low word", 64'(v), 64'hCAFE_0001);
    busRead(8'h08, v); check("R2", "high word", 64'(v), 64'hBEEF_0002);
    busRead(8'h00, v); check("R2", "target keeps 3 bits", 64'(v), 64'h5);
    check("R3", "no launch from register writes", 64'(dstValid), 64'h0);
  endtask

  task automatic testSendPop();
    logic [31:0] v;
    sendMsg(3, 64'h1111_2222_3333_4444);
    check("R3", "dst3 valid after launch", 64'(dstValid), 64'h08);
    check("R3", "dst3 head", headOf(3), 64'h1111_2222_3333_4444);
    busRead(8'h14, v); check("R4", "pending bit 3", 64'(v), 64'h08);
    busWrite(8'h0C, 32'h0);
    busWrite(8'h0C, 32'h2);
    busRead(8'h14, v); check("R3", "launch with bit0 clear ignored", 64'(v), 64'h08);
    sendMsg(3, 64'h5555_6666_7777_8888);
    popDst(3);
    check("R4", "fifo order second msg", headOf(3), 64'h5555_6666_7777_8888);
    busRead(8'h14, v); check("R6", "delivered bit 19 with pending", 64'(v), 64'h0008_0008);
    popDst(3);
    busRead(8'h14, v); check("R4", "pending clears when empty", 64'(v), 64'h0008_0000);
    popDst(5);
    busRead(8'h14, v); check("R6", "pop on empty ignored", 64'(v), 64'h0008_0000);
    check("R6", "dstValid after empty pop", 64'(dstValid), 64'h0);
    busWrite(8'h10, 32'h00FF_FF00);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    for (int k = 0; k < 5; k++) sendMsg(6, 64'hA000_0000_0000_0000 + 64'(k));
    busRead(8'h14, v); check("R5", "drop bit 14 and pending 6", 64'(v), 64'h0000_4040);
    check("R5", "head kept after drop", headOf(6), 64'hA000_0000_0000_0000);
    for (int k = 0; k < 4; k++) begin
      check("R5", "queued entry order", headOf(6), 64'hA000_0000_0000_0000 + 64'(k));
      popDst(6);
    end
    check("R5", "fifth message discarded", 64'(dstValid), 64'h0);
    busRead(8'h14, v); check("R6", "delivered 22 and drop 14", 64'(v), 64'h0040_4000);
  endtask

  task automatic testClear();
    logic [31:0] v;
    sendMsg(1, 64'h0123_4567_89AB_CDEF);
    busWrite(8'h10, 32'h0000_4000);
    busRead(8'h14, v); check("R7", "clear drop only", 64'(v), 64'h0040_0002);
    busWrite(8'h10, 32'h00FF_FF00);
    busRead(8'h14, v); check("R7", "pending survives clear", 64'(v), 64'h0000_0002);
    popDst(1);
    busWrite(8'h10, 32'h00FF_FF00);
    busRead(8'h14, v); check("R7", "all flags cleared", 64'(v), 64'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    sendMsg(2, 64'h2);
    popDst(2);
    @(negedge clk);
    busRead(8'h18, v); check("R10", "masked delivery no pend", 64'(v), 64'h0);
    check("R10", "masked delivery no irq", 64'(irq), 64'h0);
    busWrite(8'h1C, 32'h3);
    @(negedge clk);
    busRead(8'h18, v); check("R8", "delivery unmasked pend", 64'(v), 64'h1);
    check("R9", "global mask holds irq low", 64'(irq), 64'h0);
    busWrite(8'h1C, 32'h0);
    check("R9", "irq follows pend", 64'(irq), 64'h1);
    busWrite(8'h10, 32'h00FF_FF00);
    busWrite(8'h18, 32'h1);
    busRead(8'h18, v); check("R8", "W1C clears pend", 64'(v), 64'h0);
    check("R9", "irq low after clear", 64'(irq), 64'h0);
    busWrite(8'h1C, 32'h4);
    for (int k = 0; k < 5; k++) sendMsg(0, 64'(k));
    @(negedge clk);
    check("R8", "drop raises irq", 64'(irq), 64'h1);
    busWrite(8'h1C, 32'h7);
    busWrite(8'h10, 32'h00FF_FF00);
    busWrite(8'h18, 32'h1);
    for (int k = 0; k < 4; k++) popDst(0);
    @(negedge clk);
    busRead(8'h18, v); check("R10", "masked sources after drain", 64'(v), 64'h0);
    busWrite(8'h10, 32'h00FF_FF00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testSendPop();
    testOverflow();
    testClear();
    testIrq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule